// File: doc/BRIEF.md
# Group-Aware Interrupt Eligibility Mask

This block takes a word of interrupt lines and decides, per line, whether that interrupt may be signalled onward to a processor interface. It keeps one pending latch per line. A rising edge on a line configured as edge-triggered sets that latch, and software clears it through a write-1-to-clear strobe word. A level-triggered line skips the latch and counts as pending for as long as its input is high.

A pending interrupt is eligible only when its enable bit is set and its group is switched on. The group is taken from two configuration bits. A group bit of 1 puts the line in the non-secure second group. A group bit of 0 puts it in the secure second group when the modifier bit is 1, and in the first group (group zero) when the modifier bit is 0. A single-security-state control forces every modifier bit to zero, so every line whose group bit is 0 falls into group zero.

The eligibility word is registered. Priority selection among eligible lines is left to a downstream stage that reads this word.

Top module: `elig_mask`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `eligible` and `pend_latched` are all zero, whatever the lines and configuration are.
- R2: On an edge-triggered line (`trig_edge` bit 1), an input seen high at a clock edge after being low at the previous edge sets that line's latch at that edge. The latch stays set after the input falls.
- R3: On a level-triggered line (`trig_edge` bit 0), the line is pending exactly while its input is high, and its latch is never set.
- R4: A line whose `enable_bits` bit is 0 is never eligible, even when its latch is set.
- R5: A 1 in `pend_clr` clears that line's latch at the next clock edge. A 0 leaves the latch unchanged.
- R6: When a latch clear and a latch-setting edge arrive on the same line in the same cycle, the latch ends up set.
- R7: When `en_grp1_nsec` is 1, pending and enabled lines with group bit 1 are eligible.
- R8: When `en_grp1_sec` is 1, pending and enabled lines with group bit 0 and modifier bit 1 are eligible, provided `one_sec_state` is 0.
- R9: When `en_grp0` is 1, pending and enabled lines with group bit 0 and modifier bit 0 are eligible. With all three group enables at 0, nothing is eligible.
- R10: When `one_sec_state` is 1, every modifier bit counts as 0. Lines with group bit 0 then follow `en_grp0` only, and `en_grp1_sec` has no effect.
- R11: `eligible` and `pend_latched` change only at a clock edge. Each reflects the inputs present at that edge, one cycle after the inputs change.
- R12: A falling input on an edge-triggered line does not set its latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | N_LINES | Live interrupt input levels |
| trig_edge | input | N_LINES | 1 = edge-triggered, 0 = level-triggered |
| enable_bits | input | N_LINES | Per-line enable |
| group_bits | input | N_LINES | 1 = non-secure second group, 0 = secure group chosen by modifier |
| gmod_bits | input | N_LINES | Modifier: with group bit 0, 1 = secure second group, 0 = group zero |
| pend_clr | input | N_LINES | Write-1-to-clear strobe for the pending latches |
| en_grp0 | input | 1 | Enable for group zero |
| en_grp1_sec | input | 1 | Enable for the secure second group |
| en_grp1_nsec | input | 1 | Enable for the non-secure second group |
| one_sec_state | input | 1 | Forces all modifier bits to 0 |
| eligible | output | N_LINES | Registered word of lines eligible for signalling |
| pend_latched | output | N_LINES | Current pending latch contents |

## Verification
The hardest case to reach from the ports is a clear strobe and a fresh rising edge landing on the same line in the same cycle. The stimulus holds the line low for one cycle and then raises it together with the clear bit. It also pairs a clear with a falling edge, so the clear alone takes effect. Group classification is checked with a fixed word in which 16 lines sit in the non-secure group, 8 in the secure group and 8 in group zero. Each enable is then switched on alone, with and without the single-security-state control, so each class is seen in isolation.

// File: rtl/elig_pkg.sv
// Package: shared group-class type and the helper that classifies one line.
// Assumes: modifier bits are already masked by the single-security control.
package elig_pkg;

    typedef enum logic [1:0] {
        CLS_GRP0      = 2'd0,
        CLS_GRP1_SEC  = 2'd1,
        CLS_GRP1_NSEC = 2'd2
    } grp_class_e;

    // Map group and effective modifier bit to a class.
    function automatic grp_class_e classify(input logic grp, input logic mod_eff);
        if (grp)
            return CLS_GRP1_NSEC;
        else if (mod_eff)
            return CLS_GRP1_SEC;
        else
            return CLS_GRP0;
    endfunction

endpackage

// File: rtl/elig_pend_bank.sv
// Module: per-line pending latches with rising-edge set and write-1-to-clear.
// Assumes: line inputs are synchronous to clk; set wins over clear.
module elig_pend_bank #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_in,
    input  logic [N_LINES-1:0] trig_edge,
    input  logic [N_LINES-1:0] pend_clr,
    output logic [N_LINES-1:0] pend_q,
    output logic [N_LINES-1:0] pend_nxt
);

    logic [N_LINES-1:0] line_q;
    logic [N_LINES-1:0] rise;

    // Detect rising edges on edge-configured lines.
    always_comb rise = line_in & ~line_q & trig_edge;

    // Next latch value: clear first, then set so set wins.
    always_comb pend_nxt = (pend_q & ~pend_clr) | rise;

    // Register input history and latch state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            pend_q <= '0;
        end else begin
            line_q <= line_in;
            pend_q <= pend_nxt;
        end
    end

    // R2: a detected edge leaves the latch set.
    a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & $past(rise)) == $past(rise)));

    // R6: set and clear in the same cycle resolve to set.
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & $past(rise & pend_clr)) == $past(rise & pend_clr)));

    // R5: a clear without an edge empties the latch.
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & $past(pend_clr & ~rise)) == '0));

    // R12: a latch only turns on through a detected edge.
    a_r12_only_edges_set: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & ~$past(pend_q) & ~$past(rise)) == '0));

endmodule

// File: rtl/elig_group_gate.sv
// Module: per-line group permission mask from group, modifier and enables.
// Assumes: purely combinational; one instance covers all lines.
module elig_group_gate #(
    parameter int N_LINES = 32
) (
    input  logic [N_LINES-1:0] group_bits,
    input  logic [N_LINES-1:0] gmod_bits,
    input  logic               en_grp0,
    input  logic               en_grp1_sec,
    input  logic               en_grp1_nsec,
    input  logic               one_sec_state,
    output logic [N_LINES-1:0] grp_ok
);
    import elig_pkg::*;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        grp_class_e cls;
        // Classify the line with the modifier forced low in single-security mode.
        always_comb cls = classify(group_bits[i], gmod_bits[i] & ~one_sec_state);
        // Select the enable belonging to the class.
        always_comb begin
            unique case (cls)
                CLS_GRP1_NSEC: grp_ok[i] = en_grp1_nsec;
                CLS_GRP1_SEC:  grp_ok[i] = en_grp1_sec;
                default:       grp_ok[i] = en_grp0;
            endcase
        end
    end

endmodule

// File: rtl/elig_mask.sv
// Module: top of the eligibility mask; merges latch, level bypass, enable
// and group permission, then registers the result.
// Assumes: synchronous active-low reset; all inputs synchronous to clk.
module elig_mask #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_in,
    input  logic [N_LINES-1:0] trig_edge,
    input  logic [N_LINES-1:0] enable_bits,
    input  logic [N_LINES-1:0] group_bits,
    input  logic [N_LINES-1:0] gmod_bits,
    input  logic [N_LINES-1:0] pend_clr,
    input  logic               en_grp0,
    input  logic               en_grp1_sec,
    input  logic               en_grp1_nsec,
    input  logic               one_sec_state,
    output logic [N_LINES-1:0] eligible,
    output logic [N_LINES-1:0] pend_latched
);

    logic [N_LINES-1:0] pend_nxt;
    logic [N_LINES-1:0] grp_ok;
    logic [N_LINES-1:0] raw_pend;
    logic [N_LINES-1:0] elig_d;
    logic [N_LINES-1:0] elig_q;

    elig_pend_bank #(.N_LINES(N_LINES)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .trig_edge (trig_edge),
        .pend_clr  (pend_clr),
        .pend_q    (pend_latched),
        .pend_nxt  (pend_nxt)
    );

    elig_group_gate #(.N_LINES(N_LINES)) u_gate (
        .group_bits    (group_bits),
        .gmod_bits     (gmod_bits),
        .en_grp0       (en_grp0),
        .en_grp1_sec   (en_grp1_sec),
        .en_grp1_nsec  (en_grp1_nsec),
        .one_sec_state (one_sec_state),
        .grp_ok        (grp_ok)
    );

    // Pending: next latch value, or a level line that is high.
    always_comb raw_pend = pend_nxt | (~trig_edge & line_in);

    // Combine pending, enable and group permission.
    always_comb elig_d = raw_pend & enable_bits & grp_ok;

    // Register the eligibility word.
    always_ff @(posedge clk) begin
        if (!rst_n) elig_q <= '0;
        else        elig_q <= elig_d;
    end

    assign eligible = elig_q;

    // R4: a disabled line is never eligible.
    a_r4_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((eligible & ~$past(enable_bits)) == '0));

    // R9: with every group off, nothing is eligible.
    a_r9_all_groups_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !en_grp0 && !en_grp1_sec && !en_grp1_nsec) |-> (eligible == '0));

    // R10: in single-security mode the secure second group enable adds nothing.
    a_r10_single_sec: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && one_sec_state && !en_grp0 && !en_grp1_nsec) |-> (eligible == '0));

    // R3: a level line that is low with an empty latch is not eligible.
    a_r3_level_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((eligible & $past(~trig_edge & ~line_in & ~pend_nxt)) == '0));

endmodule

// File: tb/elig_mask_tb.sv
// Bench: scoreboard driving elig_mask; the driver pushes expected words,
// the monitor pops and compares them one cycle later.
module elig_mask_tb;
    localparam int N = 32;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] line_in, trig_edge, enable_bits, group_bits, gmod_bits, pend_clr;
    logic         en_grp0, en_grp1_sec, en_grp1_nsec, one_sec_state;
    logic [N-1:0] eligible, pend_latched;

    int n_checks = 0;
    int n_fails  = 0;

    logic [N-1:0] q_elig[$];
    logic [N-1:0] q_pend[$];
    string        q_tag[$];

    logic [N-1:0] m_pend, m_prev;

    elig_mask #(.N_LINES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .trig_edge(trig_edge),
        .enable_bits(enable_bits), .group_bits(group_bits), .gmod_bits(gmod_bits),
        .pend_clr(pend_clr), .en_grp0(en_grp0), .en_grp1_sec(en_grp1_sec),
        .en_grp1_nsec(en_grp1_nsec), .one_sec_state(one_sec_state),
        .eligible(eligible), .pend_latched(pend_latched)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected outcome.
    task automatic step(input logic [N-1:0] ln, input logic [N-1:0] te,
                        input logic [N-1:0] en, input logic [N-1:0] gr,
                        input logic [N-1:0] md, input logic [N-1:0] clr,
                        input logic g0, input logic g1s, input logic g1n,
                        input logic ss, input string tag);
        logic [N-1:0] rise, p, mask, mod_eff;
        @(negedge clk);
        line_in = ln; trig_edge = te; enable_bits = en; group_bits = gr;
        gmod_bits = md; pend_clr = clr; en_grp0 = g0; en_grp1_sec = g1s;
        en_grp1_nsec = g1n; one_sec_state = ss;
        rise    = ln & ~m_prev & te;
        m_pend  = (m_pend & ~clr) | rise;
        m_prev  = ln;
        p       = m_pend | (~te & ln);
        mod_eff = ss ? '0 : md;
        mask    = (g1n ? gr : '0) | (g1s ? (~gr & mod_eff) : '0) |
                  (g0 ? (~gr & ~mod_eff) : '0);
        q_elig.push_back(p & en & mask);
        q_pend.push_back(m_pend);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare just after each edge against the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_tag.size() > 0) begin
                string t;
                logic [N-1:0] e, p;
                t = q_tag.pop_front();
                e = q_elig.pop_front();
                p = q_pend.pop_front();
                check({t, " eligible"}, eligible, e);
                check({t, " latch"}, pend_latched, p);
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    localparam logic [N-1:0] ONES = '1;
    localparam logic [N-1:0] ZERO = '0;

    initial begin
        logic [N-1:0] lf;
        m_pend = '0; m_prev = '0;
        rst_n = 1'b0;
        line_in = ONES; trig_edge = ZERO; enable_bits = ONES; group_bits = ONES;
        gmod_bits = ZERO; pend_clr = ZERO; en_grp0 = 1; en_grp1_sec = 1;
        en_grp1_nsec = 1; one_sec_state = 0;
        repeat (3) @(negedge clk);
        check("R1 reset eligible", eligible, ZERO);
        check("R1 reset latch", pend_latched, ZERO);
        line_in = ZERO;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 first cycle eligible", eligible, ZERO);
        check("R1 first cycle latch", pend_latched, ZERO);

        // Level lines in the non-secure group.
        step(32'hA5A5_0F0F, ZERO, ONES, ONES, ZERO, ZERO, 1, 1, 1, 0, "R3 R7 R11 level high");
        step(ZERO, ZERO, ONES, ONES, ZERO, ZERO, 1, 1, 1, 0, "R3 level low");
        // Edge lines.
        step(32'h0000_00FF, ONES, ONES, ONES, ZERO, ZERO, 1, 1, 1, 0, "R2 rise sets");
        step(ZERO, ONES, ONES, ONES, ZERO, ZERO, 1, 1, 1, 0, "R2 R12 hold after fall");
        step(ZERO, ONES, ONES, ONES, ZERO, 32'h0000_000F, 1, 1, 1, 0, "R5 clear");
        step(ZERO, ONES, ONES, ONES, ZERO, ZERO, 1, 1, 1, 0, "R5 idle");
        step(32'h0000_0300, ONES, ONES, ONES, ZERO, 32'h0000_0300, 1, 1, 1, 0, "R6 set wins");
        step(32'h0000_3000, ONES, ONES, ONES, ZERO, ZERO, 1, 1, 1, 0, "R2 second rise");
        step(ZERO, ONES, ONES, ONES, ZERO, 32'h0000_2000, 1, 1, 1, 0, "R12 R5 fall with clear");
        step(ZERO, ONES, ZERO, ONES, ZERO, ZERO, 1, 1, 1, 0, "R4 disabled");
        step(ZERO, ONES, 32'h0000_00F0, ONES, ZERO, ZERO, 1, 1, 1, 0, "R4 partial enable");
        // Group classes with level lines all high.
        step(ONES, ZERO, ONES, 32'h0000_FFFF, 32'h00FF_00FF, ZERO, 0, 0, 1, 0, "R7 nsec only");
        step(ONES, ZERO, ONES, 32'h0000_FFFF, 32'h00FF_00FF, ZERO, 0, 1, 0, 0, "R8 sec only");
        step(ONES, ZERO, ONES, 32'h0000_FFFF, 32'h00FF_00FF, ZERO, 1, 0, 0, 0, "R9 grp0 only");
        step(ONES, ZERO, ONES, 32'h0000_FFFF, 32'h00FF_00FF, ZERO, 0, 0, 0, 0, "R9 all off");
        step(ONES, ZERO, ONES, 32'h0000_FFFF, 32'h00FF_00FF, ZERO, 1, 0, 0, 1, "R10 single grp0");
        step(ONES, ZERO, ONES, 32'h0000_FFFF, 32'h00FF_00FF, ZERO, 0, 1, 0, 1, "R10 single sec off");
        step(ONES, ZERO, ONES, 32'h0000_FFFF, 32'h00FF_00FF, ZERO, 1, 1, 1, 1, "R10 single all on");
        // Level lines never latch.
        step(ZERO, ZERO, ONES, ONES, ZERO, ONES, 1, 1, 1, 0, "R3 clear all");
        step(ONES, ZERO, ONES, ONES, ZERO, ZERO, 1, 1, 1, 0, "R3 no latch on level");
        // Mixed patterns.
        lf = 32'h1357_9BDF;
        for (int k = 0; k < 40; k++) begin
            logic [N-1:0] a, b;
            lf = {lf[N-2:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            a  = lf ^ 32'h5A5A_3C3C;
            b  = {lf[15:0], lf[31:16]};
            step(lf, a, ~b, b ^ a, lf ^ b, lf & a & b, lf[3], lf[7], lf[11], lf[13],
                 "R2 R3 R6 mixed");
        end
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule